// File: doc/BRIEF.md
# Byte-Bus Register Block with Sixteen-Bit Fields

This block is a small control and status register bank reached over an 8-bit request/acknowledge bus. It holds three 16-bit fields that each take two consecutive byte addresses, low byte at the even address and high byte at the odd one. It also holds three 8-bit fields. Every field drives its current contents to the hardware side. Every field also drives two per-field pulses: an access pulse that marks any software access to the field, and a modify pulse that marks a software action that changes the field's contents.

Two of the wide fields take software writes. A low-byte write is held in a staging byte, and the high-byte write commits both bytes at once. One of these two fields, and also the wide read-to-clear field, keeps a high-byte snapshot when its low byte is read. A two-byte read therefore returns one coherent word, even when the read itself clears the field. The read-to-clear fields can also be loaded from hardware through a load strobe. The last byte field is a read-only window onto a hardware input.

A request is taken in the cycle in which `reqValid` is high. The access and modify pulses are driven in that same cycle. Register contents and the registered read data change at the following clock edge, and `ackValid` is high for exactly that following cycle. Reset is synchronous and active high.

Top module: `regBlockWide`

## Requirements
- R1: Synchronous reset sets the field outputs to 0x1234 (dual-buffered), 0xABCD (write-staged), 0x1030 (wide clear), 0x12 (byte) and 0x1E (byte clear). While reset is applied and while no request is present, `ackValid`, `fieldSwacc` and `fieldSwmod` are low.
- R2: Every request produces `ackValid` high for exactly the next cycle, with read data in `ackRdata`. The address map is: 0/1 dual-buffered low/high, 2/3 write-staged low/high, 4/5 wide clear low/high, 6 byte, 7 byte clear, 8 hardware status. Strobe bit index: 0 dual-buffered, 1 write-staged, 2 wide clear, 3 byte, 4 byte clear, 5 status.
- R3: A low-byte write (address 0 or 2) leaves the field output unchanged and raises no strobe. The high-byte write (address 1 or 3) loads {written byte, staged low byte}.
- R4: A high-byte commit or a byte-field write raises that field's access and modify bits together in the request cycle. The field output shows the new contents from the next cycle and not in the request cycle. Both bits are low again once the request is gone.
- R5: A read of address 4 or 7 returns the field's contents, raises its access and modify bits in the request cycle, and leaves the field at zero from the next cycle.
- R6: A read of address 0 or 4 captures the field's high byte. A later read of address 1 or 5 returns that captured byte and raises no strobe, even if the field has changed since.
- R7: A hardware load strobe writes the next value into the matching clear field at the next edge. When a clearing read happens in the same cycle, the clear wins.
- R8: The status field at address 8 ignores writes and raises no strobe for them. A read returns `hwStatusIn` and raises only access bit 5, for exactly the request cycle.
- R9: A request to any address above 8 returns zero, raises no strobe and changes no field.
- R10: Reset empties the staging bytes and the snapshots. A high-byte write with no low-byte write since reset loads a low byte of zero, and a high-byte read with no low-byte read since reset returns zero.
- R11: Reads of the software-writable fields raise the access bit but not the modify bit: address 0, both bytes of the write-staged field, and address 6. At most one access bit is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W (4) | Byte address |
| reqWdata | input | BUS_W (8) | Write byte |
| ackValid | output | 1 | Acknowledge, one cycle after the request |
| ackRdata | output | BUS_W (8) | Read byte, valid with ackValid |
| bothValue | output | 2*BUS_W (16) | Dual-buffered field contents |
| wbufValue | output | 2*BUS_W (16) | Write-staged field contents |
| clrValue | output | 2*BUS_W (16) | Wide read-to-clear field contents |
| hwClrNext | input | 2*BUS_W (16) | Hardware value for the wide clear field |
| hwClrLoad | input | 1 | Load strobe for the wide clear field |
| byteValue | output | BUS_W (8) | Byte field contents |
| byteClrValue | output | BUS_W (8) | Byte read-to-clear field contents |
| hwByteClrNext | input | BUS_W (8) | Hardware value for the byte clear field |
| hwByteClrLoad | input | 1 | Load strobe for the byte clear field |
| hwStatusIn | input | BUS_W (8) | Hardware status read at address 8 |
| fieldSwacc | output | 6 | Per-field software access pulses |
| fieldSwmod | output | 6 | Per-field software modify pulses |

## Verification
The bench attacks three corner cases. The first is the torn wide write: a block that commits on the low byte would show the output changing after address 0. The second is the stale or torn snapshot: a block that reads the high byte live would return the post-write or post-clear byte instead of the captured one, and a block whose snapshot survives reset would return old data. The third is strobe timing: the bench checks that the output keeps its old value while the modify pulse is high. This catches a design that updates too early or pulses a cycle late. It also checks that a clearing read wins over a same-cycle hardware load, and that writes to the status address and accesses to unmapped addresses stay silent.

// File: rtl/regBlkPkg.sv
package regBlkPkg;

  localparam int NUM_FIELDS = 6;
  localparam int FLD_BOTH    = 0;
  localparam int FLD_WBUF    = 1;
  localparam int FLD_CLR     = 2;
  localparam int FLD_BYTE    = 3;
  localparam int FLD_BYTECLR = 4;
  localparam int FLD_STATUS  = 5;

  localparam int A_BOTH_LO  = 0;
  localparam int A_BOTH_HI  = 1;
  localparam int A_WBUF_LO  = 2;
  localparam int A_WBUF_HI  = 3;
  localparam int A_CLR_LO   = 4;
  localparam int A_CLR_HI   = 5;
  localparam int A_BYTE     = 6;
  localparam int A_BYTECLR  = 7;
  localparam int A_STATUS   = 8;
  localparam int LAST_ADDR  = A_STATUS;

  typedef enum logic [3:0] {
    RD_NONE, RD_BOTH_LO, RD_BOTH_HI, RD_WBUF_LO, RD_WBUF_HI,
    RD_CLR_LO, RD_CLR_HI, RD_BYTE, RD_BYTECLR, RD_STATUS
  } rdSel_e;

  typedef struct packed {
    logic   bothLoWr;
    logic   bothHiWr;
    logic   bothRdLo;
    logic   wbufLoWr;
    logic   wbufHiWr;
    logic   clrWideRd;
    logic   byteWr;
    logic   byteClrRd;
    rdSel_e rdSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/regCtrl.sv
module regCtrl
  import regBlkPkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic                  reqValid,
  input  logic                  reqWrite,
  input  logic [ADDR_W-1:0]     reqAddr,
  output ctrlStrobe_t           strobe,
  output logic [NUM_FIELDS-1:0] fieldSwacc,
  output logic [NUM_FIELDS-1:0] fieldSwmod
);

  logic isWr;
  logic isRd;

  assign isWr = reqValid & reqWrite;
  assign isRd = reqValid & ~reqWrite;

  always_comb begin
    strobe     = '0;
    strobe.rdSel = RD_NONE;
    fieldSwacc = '0;
    fieldSwmod = '0;
    case (int'(reqAddr))
      A_BOTH_LO: begin
        strobe.bothLoWr = isWr;
        strobe.bothRdLo = isRd;
        if (isRd) strobe.rdSel = RD_BOTH_LO;
        fieldSwacc[FLD_BOTH] = isRd;
      end
      A_BOTH_HI: begin
        strobe.bothHiWr = isWr;
        if (isRd) strobe.rdSel = RD_BOTH_HI;
        fieldSwacc[FLD_BOTH] = isWr;
        fieldSwmod[FLD_BOTH] = isWr;
      end
      A_WBUF_LO: begin
        strobe.wbufLoWr = isWr;
        if (isRd) strobe.rdSel = RD_WBUF_LO;
        fieldSwacc[FLD_WBUF] = isRd;
      end
      A_WBUF_HI: begin
        strobe.wbufHiWr = isWr;
        if (isRd) strobe.rdSel = RD_WBUF_HI;
        fieldSwacc[FLD_WBUF] = reqValid;
        fieldSwmod[FLD_WBUF] = isWr;
      end
      A_CLR_LO: begin
        strobe.clrWideRd = isRd;
        if (isRd) strobe.rdSel = RD_CLR_LO;
        fieldSwacc[FLD_CLR] = isRd;
        fieldSwmod[FLD_CLR] = isRd;
      end
      A_CLR_HI: begin
        if (isRd) strobe.rdSel = RD_CLR_HI;
      end
      A_BYTE: begin
        strobe.byteWr = isWr;
        if (isRd) strobe.rdSel = RD_BYTE;
        fieldSwacc[FLD_BYTE] = reqValid;
        fieldSwmod[FLD_BYTE] = isWr;
      end
      A_BYTECLR: begin
        strobe.byteClrRd = isRd;
        if (isRd) strobe.rdSel = RD_BYTECLR;
        fieldSwacc[FLD_BYTECLR] = isRd;
        fieldSwmod[FLD_BYTECLR] = isRd;
      end
      A_STATUS: begin
        if (isRd) strobe.rdSel = RD_STATUS;
        fieldSwacc[FLD_STATUS] = isRd;
      end
      default: begin
      end
    endcase
  end

endmodule

// File: rtl/wideRwField.sv
module wideRwField #(
  parameter int                BUS_W     = 8,
  parameter logic [2*BUS_W-1:0] RESET_VAL = '0,
  parameter bit                READ_BUF  = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               lowWr,
  input  logic               highWr,
  input  logic               rdLo,
  input  logic [BUS_W-1:0]   wdata,
  output logic [2*BUS_W-1:0] value,
  output logic [BUS_W-1:0]   loByte,
  output logic [BUS_W-1:0]   hiByte
);

  localparam int WORD_W = 2 * BUS_W;

  logic [BUS_W-1:0] stageLo;

  always_ff @(posedge clk) begin
    if (rst) begin
      value   <= RESET_VAL;
      stageLo <= '0;
    end else begin
      if (lowWr)  stageLo <= wdata;
      if (highWr) value   <= {wdata, stageLo};
    end
  end

  assign loByte = value[BUS_W-1:0];

  generate
    if (READ_BUF) begin : gSnap
      logic [BUS_W-1:0] snapHi;
      always_ff @(posedge clk) begin
        if (rst)       snapHi <= '0;
        else if (rdLo) snapHi <= value[WORD_W-1:BUS_W];
      end
      assign hiByte = snapHi;
    end else begin : gLive
      logic unusedRdLo;
      assign unusedRdLo = rdLo;
      assign hiByte = value[WORD_W-1:BUS_W];
    end
  endgenerate

endmodule

// File: rtl/rclrField.sv
module rclrField #(
  parameter int             BUS_W     = 8,
  parameter int             W         = 16,
  parameter logic [W-1:0]   RESET_VAL = '0,
  parameter bit             READ_BUF  = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clearRd,
  input  logic             hwLoad,
  input  logic [W-1:0]     hwNext,
  output logic [W-1:0]     value,
  output logic [BUS_W-1:0] hiByte
);

  always_ff @(posedge clk) begin
    if (rst)          value <= RESET_VAL;
    else if (clearRd) value <= '0;
    else if (hwLoad)  value <= hwNext;
  end

  generate
    if (READ_BUF && (W > BUS_W)) begin : gSnap
      logic [W-BUS_W-1:0] snapHi;
      always_ff @(posedge clk) begin
        if (rst)          snapHi <= '0;
        else if (clearRd) snapHi <= value[W-1:BUS_W];
      end
      assign hiByte = BUS_W'(snapHi);
    end else begin : gNone
      assign hiByte = '0;
    end
  endgenerate

endmodule

// File: rtl/regDatapath.sv
module regDatapath
  import regBlkPkg::*;
#(
  parameter int                 BUS_W         = 8,
  parameter logic [2*BUS_W-1:0] BOTH_RESET    = 16'h1234,
  parameter logic [2*BUS_W-1:0] WBUF_RESET    = 16'hABCD,
  parameter logic [2*BUS_W-1:0] CLR_RESET     = 16'h1030,
  parameter logic [BUS_W-1:0]   BYTE_RESET    = 8'h12,
  parameter logic [BUS_W-1:0]   BYTECLR_RESET = 8'd30
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reqValid,
  input  logic [BUS_W-1:0]   reqWdata,
  input  ctrlStrobe_t        strobe,
  input  logic [2*BUS_W-1:0] hwClrNext,
  input  logic               hwClrLoad,
  input  logic [BUS_W-1:0]   hwByteClrNext,
  input  logic               hwByteClrLoad,
  input  logic [BUS_W-1:0]   hwStatusIn,
  output logic               ackValid,
  output logic [BUS_W-1:0]   ackRdata,
  output logic [2*BUS_W-1:0] bothValue,
  output logic [2*BUS_W-1:0] wbufValue,
  output logic [2*BUS_W-1:0] clrValue,
  output logic [BUS_W-1:0]   byteValue,
  output logic [BUS_W-1:0]   byteClrValue
);

  logic [BUS_W-1:0] bothLo, bothHi, wbufLo, wbufHi, clrHi, unusedByteHi;
  logic [BUS_W-1:0] rdNext;

  wideRwField #(.BUS_W(BUS_W), .RESET_VAL(BOTH_RESET), .READ_BUF(1'b1)) uBoth (
    .clk(clk), .rst(rst),
    .lowWr(strobe.bothLoWr), .highWr(strobe.bothHiWr), .rdLo(strobe.bothRdLo),
    .wdata(reqWdata), .value(bothValue), .loByte(bothLo), .hiByte(bothHi)
  );

  wideRwField #(.BUS_W(BUS_W), .RESET_VAL(WBUF_RESET), .READ_BUF(1'b0)) uWbuf (
    .clk(clk), .rst(rst),
    .lowWr(strobe.wbufLoWr), .highWr(strobe.wbufHiWr), .rdLo(1'b0),
    .wdata(reqWdata), .value(wbufValue), .loByte(wbufLo), .hiByte(wbufHi)
  );

  rclrField #(.BUS_W(BUS_W), .W(2*BUS_W), .RESET_VAL(CLR_RESET), .READ_BUF(1'b1)) uClr (
    .clk(clk), .rst(rst),
    .clearRd(strobe.clrWideRd), .hwLoad(hwClrLoad), .hwNext(hwClrNext),
    .value(clrValue), .hiByte(clrHi)
  );

  rclrField #(.BUS_W(BUS_W), .W(BUS_W), .RESET_VAL(BYTECLR_RESET), .READ_BUF(1'b0)) uByteClr (
    .clk(clk), .rst(rst),
    .clearRd(strobe.byteClrRd), .hwLoad(hwByteClrLoad), .hwNext(hwByteClrNext),
    .value(byteClrValue), .hiByte(unusedByteHi)
  );

  always_ff @(posedge clk) begin
    if (rst)                byteValue <= BYTE_RESET;
    else if (strobe.byteWr) byteValue <= reqWdata;
  end

  always_comb begin
    case (strobe.rdSel)
      RD_BOTH_LO: rdNext = bothLo;
      RD_BOTH_HI: rdNext = bothHi;
      RD_WBUF_LO: rdNext = wbufLo;
      RD_WBUF_HI: rdNext = wbufHi;
      RD_CLR_LO:  rdNext = clrValue[BUS_W-1:0];
      RD_CLR_HI:  rdNext = clrHi;
      RD_BYTE:    rdNext = byteValue;
      RD_BYTECLR: rdNext = byteClrValue;
      RD_STATUS:  rdNext = hwStatusIn;
      default:    rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ackValid <= 1'b0;
      ackRdata <= '0;
    end else begin
      ackValid <= reqValid;
      ackRdata <= rdNext;
    end
  end

endmodule

// File: rtl/regBlockWide.sv
module regBlockWide
  import regBlkPkg::*;
#(
  parameter int                 BUS_W         = 8,
  parameter int                 ADDR_W        = 4,
  parameter logic [2*BUS_W-1:0] BOTH_RESET    = 16'h1234,
  parameter logic [2*BUS_W-1:0] WBUF_RESET    = 16'hABCD,
  parameter logic [2*BUS_W-1:0] CLR_RESET     = 16'h1030,
  parameter logic [BUS_W-1:0]   BYTE_RESET    = 8'h12,
  parameter logic [BUS_W-1:0]   BYTECLR_RESET = 8'd30
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reqValid,
  input  logic                  reqWrite,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic [BUS_W-1:0]      reqWdata,
  output logic                  ackValid,
  output logic [BUS_W-1:0]      ackRdata,
  output logic [2*BUS_W-1:0]    bothValue,
  output logic [2*BUS_W-1:0]    wbufValue,
  output logic [2*BUS_W-1:0]    clrValue,
  input  logic [2*BUS_W-1:0]    hwClrNext,
  input  logic                  hwClrLoad,
  output logic [BUS_W-1:0]      byteValue,
  output logic [BUS_W-1:0]      byteClrValue,
  input  logic [BUS_W-1:0]      hwByteClrNext,
  input  logic                  hwByteClrLoad,
  input  logic [BUS_W-1:0]      hwStatusIn,
  output logic [NUM_FIELDS-1:0] fieldSwacc,
  output logic [NUM_FIELDS-1:0] fieldSwmod
);

  ctrlStrobe_t strobe;

  regCtrl #(.ADDR_W(ADDR_W)) uCtrl (
    .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .strobe(strobe), .fieldSwacc(fieldSwacc), .fieldSwmod(fieldSwmod)
  );

  regDatapath #(
    .BUS_W(BUS_W), .BOTH_RESET(BOTH_RESET), .WBUF_RESET(WBUF_RESET),
    .CLR_RESET(CLR_RESET), .BYTE_RESET(BYTE_RESET), .BYTECLR_RESET(BYTECLR_RESET)
  ) uData (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWdata(reqWdata), .strobe(strobe),
    .hwClrNext(hwClrNext), .hwClrLoad(hwClrLoad),
    .hwByteClrNext(hwByteClrNext), .hwByteClrLoad(hwByteClrLoad),
    .hwStatusIn(hwStatusIn), .ackValid(ackValid), .ackRdata(ackRdata),
    .bothValue(bothValue), .wbufValue(wbufValue), .clrValue(clrValue),
    .byteValue(byteValue), .byteClrValue(byteClrValue)
  );

endmodule

// File: rtl/regBlockWideChecker.sv
module regBlockWideChecker
  import regBlkPkg::*;
#(
  parameter int BUS_W  = 8,
  parameter int ADDR_W = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  reqValid,
  input logic                  reqWrite,
  input logic [ADDR_W-1:0]     reqAddr,
  input logic                  ackValid,
  input logic [BUS_W-1:0]      ackRdata,
  input logic [2*BUS_W-1:0]    bothValue,
  input logic [2*BUS_W-1:0]    clrValue,
  input logic [NUM_FIELDS-1:0] fieldSwacc,
  input logic [NUM_FIELDS-1:0] fieldSwmod
);

  a_r2_ack_follows_req: assert property (@(posedge clk) disable iff (rst)
    reqValid |=> ackValid);

  a_r2_no_spurious_ack: assert property (@(posedge clk) disable iff (rst)
    !reqValid |=> !ackValid);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !reqValid |-> (fieldSwacc == '0 && fieldSwmod == '0));

  a_r9_unmapped_quiet: assert property (@(posedge clk) disable iff (rst)
    (reqValid && int'(reqAddr) > LAST_ADDR) |-> (fieldSwacc == '0 && fieldSwmod == '0));

  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (reqValid && !reqWrite && int'(reqAddr) > LAST_ADDR) |=> (ackRdata == '0));

  a_r3_low_write_holds: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqWrite && int'(reqAddr) == A_BOTH_LO) |=> $stable(bothValue));

  a_r4_change_needs_swmod: assert property (@(posedge clk) disable iff (rst)
    !fieldSwmod[FLD_BOTH] |=> $stable(bothValue));

  a_r5_clear_zero: assert property (@(posedge clk) disable iff (rst)
    fieldSwmod[FLD_CLR] |=> (clrValue == '0));

  a_r8_status_write_quiet: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqWrite && int'(reqAddr) == A_STATUS) |-> (fieldSwacc == '0 && fieldSwmod == '0));

  a_r11_single_access: assert property (@(posedge clk) disable iff (rst)
    $onehot0(fieldSwacc));

endmodule

bind regBlockWide regBlockWideChecker #(.BUS_W(BUS_W), .ADDR_W(ADDR_W)) uChk (.*);

// File: tb/tb_regBlockWide.sv
`timescale 1ns/1ps
module tb_regBlockWide;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [3:0]  reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic        ackValid;
  logic [7:0]  ackRdata;
  logic [15:0] bothValue, wbufValue, clrValue;
  logic [15:0] hwClrNext = '0;
  logic        hwClrLoad = 1'b0;
  logic [7:0]  byteValue, byteClrValue;
  logic [7:0]  hwByteClrNext = '0;
  logic        hwByteClrLoad = 1'b0;
  logic [7:0]  hwStatusIn = '0;
  logic [5:0]  fieldSwacc, fieldSwmod;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [8:0] expQ[$];
  string      tagQ[$];

  always #2.5 clk = ~clk;

  regBlockWide dut (.*);

  task automatic check(bit ok, string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic checkVal(string req, logic [15:0] act, logic [15:0] exp);
    check(act === exp, req, act, exp);
  endtask

  task automatic startAccess(bit wr, int addr, logic [7:0] d, logic [7:0] exp,
                             logic [5:0] expAcc, logic [5:0] expMod, string req);
    @(negedge clk);
    reqValid = 1'b1;
    reqWrite = wr;
    reqAddr  = 4'(addr);
    reqWdata = d;
    expQ.push_back({~wr, exp});
    tagQ.push_back(req);
    #1;
    check(fieldSwacc === expAcc, {req, " swacc"}, 16'(fieldSwacc), 16'(expAcc));
    check(fieldSwmod === expMod, {req, " swmod"}, 16'(fieldSwmod), 16'(expMod));
  endtask

  task automatic finishAccess();
    @(negedge clk);
    reqValid = 1'b0;
    reqWrite = 1'b0;
  endtask

  task automatic access(bit wr, int addr, logic [7:0] d, logic [7:0] exp,
                        logic [5:0] expAcc, logic [5:0] expMod, string req);
    startAccess(wr, addr, d, exp, expAcc, expMod, req);
    finishAccess();
  endtask

  task automatic idleQuiet(string req);
    #1;
    check(fieldSwacc === 6'b0 && fieldSwmod === 6'b0, {req, " idle strobes"},
          16'({fieldSwacc, fieldSwmod}), 16'h0);
  endtask

  // Scoreboard monitor: every acknowledge pops one expected item
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (ackValid === 1'b1) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R2 unexpected ack", 16'(ackRdata), 16'h0);
        end else begin
          logic [8:0] item;
          string      t;
          item = expQ.pop_front();
          t = tagQ.pop_front();
          if (item[8]) check(ackRdata === item[7:0], {t, " rdata"}, 16'(ackRdata), 16'(item[7:0]));
          else         check(1'b1, t, 16'h0, 16'h0);
        end
      end
    end
  end

  initial begin
    #(5 * 20000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state, observed while reset is held
    checkVal("R1 ack in reset", 16'(ackValid), 16'h0);
    rst = 1'b0;
    #1;
    checkVal("R1 both reset", bothValue, 16'h1234);
    checkVal("R1 wbuf reset", wbufValue, 16'hABCD);
    checkVal("R1 clr reset", clrValue, 16'h1030);
    checkVal("R1 byte reset", 16'(byteValue), 16'h12);
    checkVal("R1 byteclr reset", 16'(byteClrValue), 16'h1E);
    idleQuiet("R1");

    // R10 snapshots empty after reset
    access(0, 1, 8'h00, 8'h00, 6'b0, 6'b0, "R10 both hi snapshot");
    access(0, 5, 8'h00, 8'h00, 6'b0, 6'b0, "R10 clr hi snapshot");

    // R3 / R4 staged commit on the dual-buffered field
    access(1, 0, 8'h67, 8'h00, 6'b0, 6'b0, "R3 low write");
    checkVal("R3 low write no change", bothValue, 16'h1234);
    startAccess(1, 1, 8'h45, 8'h00, 6'b000001, 6'b000001, "R4 commit");
    checkVal("R4 old value during pulse", bothValue, 16'h1234);
    finishAccess();
    checkVal("R3 commit value", bothValue, 16'h4567);
    idleQuiet("R4");

    access(1, 2, 8'h12, 8'h00, 6'b0, 6'b0, "R3 wbuf low");
    checkVal("R3 wbuf unchanged", wbufValue, 16'hABCD);
    access(1, 3, 8'hEF, 8'h00, 6'b000010, 6'b000010, "R4 wbuf commit");
    checkVal("R3 wbuf commit value", wbufValue, 16'hEF12);

    // R11 / R6 read snapshot survives an intervening write
    access(0, 0, 8'h00, 8'h67, 6'b000001, 6'b0, "R11 both low read");
    access(1, 0, 8'h00, 8'h00, 6'b0, 6'b0, "R3 low write 2");
    access(1, 1, 8'h99, 8'h00, 6'b000001, 6'b000001, "R4 commit 2");
    checkVal("R3 commit 2 value", bothValue, 16'h9900);
    access(0, 1, 8'h00, 8'h45, 6'b0, 6'b0, "R6 both hi from snapshot");
    access(0, 3, 8'h00, 8'hEF, 6'b000010, 6'b0, "R11 wbuf hi read");
    access(0, 2, 8'h00, 8'h12, 6'b000010, 6'b0, "R11 wbuf lo read");

    // R5 / R6 wide read-to-clear
    startAccess(0, 4, 8'h00, 8'h30, 6'b000100, 6'b000100, "R5 clr low read");
    checkVal("R5 old value during pulse", clrValue, 16'h1030);
    finishAccess();
    checkVal("R5 clr cleared", clrValue, 16'h0000);
    access(0, 5, 8'h00, 8'h10, 6'b0, 6'b0, "R6 clr hi from snapshot");
    access(0, 7, 8'h00, 8'h1E, 6'b010000, 6'b010000, "R5 byteclr read");
    checkVal("R5 byteclr cleared", 16'(byteClrValue), 16'h0);
    access(0, 7, 8'h00, 8'h00, 6'b010000, 6'b010000, "R5 byteclr reread");

    // R7 hardware load, then clear against simultaneous load
    @(negedge clk);
    hwClrNext = 16'hBEEF; hwClrLoad = 1'b1;
    hwByteClrNext = 8'h42; hwByteClrLoad = 1'b1;
    @(negedge clk);
    hwClrLoad = 1'b0; hwByteClrLoad = 1'b0;
    checkVal("R7 clr load", clrValue, 16'hBEEF);
    checkVal("R7 byteclr load", 16'(byteClrValue), 16'h42);
    startAccess(0, 4, 8'h00, 8'hEF, 6'b000100, 6'b000100, "R7 clear vs load");
    hwClrNext = 16'h5555; hwClrLoad = 1'b1;
    finishAccess();
    hwClrLoad = 1'b0;
    checkVal("R7 clear wins", clrValue, 16'h0000);
    access(0, 5, 8'h00, 8'hBE, 6'b0, 6'b0, "R6 clr hi after load");
    access(0, 7, 8'h00, 8'h42, 6'b010000, 6'b010000, "R7 byteclr read loaded");

    // R4 / R11 byte field
    startAccess(1, 6, 8'h34, 8'h00, 6'b001000, 6'b001000, "R4 byte write");
    checkVal("R4 byte old during pulse", 16'(byteValue), 16'h12);
    finishAccess();
    checkVal("R4 byte new", 16'(byteValue), 16'h34);
    access(0, 6, 8'h00, 8'h34, 6'b001000, 6'b0, "R11 byte read");

    // R8 status read-only
    hwStatusIn = 8'h99;
    access(1, 8, 8'h00, 8'h00, 6'b0, 6'b0, "R8 status write ignored");
    access(0, 8, 8'h00, 8'h99, 6'b100000, 6'b0, "R8 status read");
    idleQuiet("R8");

    // R9 unmapped
    access(0, 12, 8'h00, 8'h00, 6'b0, 6'b0, "R9 unmapped read");
    access(1, 15, 8'hFF, 8'h00, 6'b0, 6'b0, "R9 unmapped write");
    checkVal("R9 both unchanged", bothValue, 16'h9900);
    checkVal("R9 byte unchanged", 16'(byteValue), 16'h34);

    // R10 reset drops staged byte and snapshot
    access(0, 0, 8'h00, 8'h00, 6'b000001, 6'b0, "R11 both low read 2");
    access(1, 0, 8'hAA, 8'h00, 6'b0, 6'b0, "R10 stage before reset");
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    #1;
    checkVal("R1 both after reset", bothValue, 16'h1234);
    access(0, 1, 8'h00, 8'h00, 6'b0, 6'b0, "R10 snapshot cleared");
    access(1, 1, 8'h11, 8'h00, 6'b000001, 6'b000001, "R10 commit after reset");
    checkVal("R10 staged byte cleared", bothValue, 16'h1100);

    repeat (3) @(negedge clk);
    checkVal("R2 queue drained", 16'(expQ.size()), 16'h0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule